// File: doc/BRIEF.md
# Threshold-Search Learning Sequencer

This block sequences the training pass of a single learning neuron. A host pushes training samples over a 32-bit valid/ready input stream, and the block stores them in an on-chip sample store. A start strobe then runs the search. For each candidate function, a small ALU first transforms every stored sample and writes the results to a result buffer. The block then sweeps every threshold value over that buffer and counts the misclassified samples. The best threshold found is kept across all functions.

When the search ends, the block returns the winning function, the threshold and its error index as two words on a 32-bit valid/ready output stream. It then pulses `done`.

Input back-pressure works as follows: `in_ready` is high only while the block is idle and the store has room, and a word is taken on every cycle where `in_valid` and `in_ready` are both high. Output back-pressure works as follows: `out_valid` and `out_data` hold until `out_ready` is seen, and the sequencer stalls without losing anything. `start` and `done` are plain control pins.

Top module: `thresh_learn_seq`

## Requirements
- R1: While idle, `in_ready` is high until DEPTH words are held. Accepted words fill the store in arrival order from entry 0. Once the store is full, `in_ready` is low and further words are not taken.
- R2: `start` begins a search only when the block is idle and at least one sample is loaded. A start with an empty store, or during a search, has no effect.
- R3: From the start of a search until `done`, `in_ready` is low and no input word is accepted.
- R4: Sample word fields are: feature A in bits [7:0], feature B in bits [15:8], class label in bit 31. The candidate functions, in search order, are: 0 = A, 1 = B, 2 = (A+B)>>1 with a 9-bit sum, 3 = A XOR B.
- R5: For function f and threshold t, the index is the number of samples where (f(sample) >= t) differs from the label. Thresholds are swept from 0 to 255, and all thresholds of one function are swept before the next function begins.
- R6: The best index starts each search at its all-ones value. The best is replaced only by a strictly lower index, so on a tie the earlier function wins, and within a function the lower threshold wins.
- R7: The result is sent as two words. The first word holds the threshold in bits [7:0] and the function number in bits [9:8], with zeros elsewhere. The second word holds the index zero-extended.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R9: `done` is high for exactly one cycle, in the cycle after the second output word is accepted. The store is then empty, so the next load starts again at entry 0.
- R10: After reset, `in_ready` is high, `out_valid` is low and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input stream word valid |
| in_ready | output | 1 | Input stream can accept a word |
| in_data | input | 32 | Training sample word |
| start | input | 1 | Begin the search |
| out_valid | output | 1 | Output stream word valid |
| out_ready | input | 1 | Host takes the output word |
| out_data | output | 32 | Result word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs several small training sets, and each one is built so that the winning function differs: feature A alone, feature B alone, the average, and the XOR. A wrong function order or a broken ALU op therefore moves the winner to a different function. One set has inverted labels, so no function classifies it perfectly. This forces ties at index 1, which exposes any tie rule other than keeping the earliest. Single-sample sets with each label pin down the `>=` boundary of the threshold compare. A full-store run with a stalled output, and starts issued while busy or while empty, cover capacity, back-pressure and start filtering.

// File: rtl/ntl_pkg.sv
package ntl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMP,
    ST_SCAN,
    ST_OUT0,
    ST_OUT1,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/ntl_sample_store.sv
module ntl_sample_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle,
  input  logic              clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CW-1:0]     count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_en;

  assign in_ready = idle && (count < CW'(DEPTH));
  assign wr_en    = in_valid && in_ready;
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[count[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (wr_en) count <= count + CW'(1);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R1
endmodule

// File: rtl/ntl_alu.sv
module ntl_alu #(
  parameter int RES_W    = 8,
  parameter int NUM_FUNC = 4,
  localparam int FW = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
  input  logic [RES_W-1:0] op_a,
  input  logic [RES_W-1:0] op_b,
  input  logic [FW-1:0]    sel,
  output logic [RES_W-1:0] res
);
  logic [RES_W-1:0] opres [NUM_FUNC];

  for (genvar g = 0; g < NUM_FUNC; g++) begin : g_op
    if (g == 0) begin : g_a
      assign opres[g] = op_a;
    end else if (g == 1) begin : g_b
      assign opres[g] = op_b;
    end else if (g == 2) begin : g_avg
      logic [RES_W:0] sum;
      assign sum      = {1'b0, op_a} + {1'b0, op_b};
      assign opres[g] = sum[RES_W:1];
    end else if (g == 3) begin : g_xor
      assign opres[g] = op_a ^ op_b;
    end else begin : g_sub
      assign opres[g] = op_a - op_b;
    end
  end

  assign res = opres[sel];
endmodule

// File: rtl/ntl_best_keeper.sv
module ntl_best_keeper #(
  parameter int RES_W = 8,
  parameter int FW    = 2,
  parameter int CW    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cand_valid,
  input  logic [CW-1:0]    cand_idx,
  input  logic [RES_W-1:0] cand_thr,
  input  logic [FW-1:0]    cand_func,
  output logic [CW-1:0]    best_idx,
  output logic [RES_W-1:0] best_thr,
  output logic [FW-1:0]    best_func
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      best_idx  <= '1;
      best_thr  <= '0;
      best_func <= '0;
    end else if (cand_valid && (cand_idx < best_idx)) begin
      best_idx  <= cand_idx;
      best_thr  <= cand_thr;
      best_func <= cand_func;
    end
  end

  AST_BEST_MONO: assert property (@(posedge clk) disable iff (rst)
    !clr |=> best_idx <= $past(best_idx)); // R6
  AST_KEEP_ON_TIE: assert property (@(posedge clk) disable iff (rst)
    (!clr && !(cand_valid && (cand_idx < best_idx))) |=> $stable(best_thr) && $stable(best_func)); // R6
endmodule

// File: rtl/thresh_learn_seq.sv
module thresh_learn_seq #(
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 1024,
  parameter int RES_W    = 8,
  parameter int NUM_FUNC = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int FW = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              start,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              done
);
  import ntl_pkg::*;

  seq_state_e        state;
  logic [AW-1:0]     pos;
  logic [FW-1:0]     func;
  logic [RES_W-1:0]  thr;
  logic [CW-1:0]     err;
  logic [CW-1:0]     count;
  logic [DATA_W-1:0] sample;
  logic [RES_W-1:0]  alu_res;
  logic [RES_W:0]    rbuf [DEPTH];
  logic [RES_W:0]    rword;
  logic              hit, last_pos, go;
  logic              cand_valid;
  logic [CW-1:0]     cand_idx;
  logic [CW-1:0]     best_idx;
  logic [RES_W-1:0]  best_thr;
  logic [FW-1:0]     best_func;

  ntl_sample_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .idle(state == ST_IDLE), .clr(state == ST_DONE),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rd_addr(pos), .rd_data(sample), .count(count)
  );

  ntl_alu #(.RES_W(RES_W), .NUM_FUNC(NUM_FUNC)) u_alu (
    .op_a(sample[RES_W-1:0]), .op_b(sample[2*RES_W-1:RES_W]),
    .sel(func), .res(alu_res)
  );

  ntl_best_keeper #(.RES_W(RES_W), .FW(FW), .CW(CW)) u_best (
    .clk(clk), .rst(rst), .clr(go), .cand_valid(cand_valid),
    .cand_idx(cand_idx), .cand_thr(thr), .cand_func(func),
    .best_idx(best_idx), .best_thr(best_thr), .best_func(best_func)
  );

  assign go         = (state == ST_IDLE) && start && (count != '0);
  assign last_pos   = (CW'(pos) == count - CW'(1));
  assign rword      = rbuf[pos];
  assign hit        = (rword[RES_W-1:0] >= thr) != rword[RES_W];
  assign cand_valid = (state == ST_SCAN) && last_pos;
  assign cand_idx   = err + CW'(hit);

  always_ff @(posedge clk) begin
    if (state == ST_COMP) rbuf[pos] <= {sample[DATA_W-1], alu_res};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pos   <= '0;
      func  <= '0;
      thr   <= '0;
      err   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          state <= ST_COMP;
          pos   <= '0;
          func  <= '0;
        end
        ST_COMP: begin
          if (last_pos) begin
            state <= ST_SCAN;
            pos   <= '0;
            thr   <= '0;
            err   <= '0;
          end else begin
            pos <= pos + AW'(1);
          end
        end
        ST_SCAN: begin
          if (last_pos) begin
            pos <= '0;
            err <= '0;
            if (thr == {RES_W{1'b1}}) begin
              if (func == FW'(NUM_FUNC - 1)) begin
                state <= ST_OUT0;
              end else begin
                func  <= func + FW'(1);
                state <= ST_COMP;
              end
            end else begin
              thr <= thr + RES_W'(1);
            end
          end else begin
            err <= cand_idx;
            pos <= pos + AW'(1);
          end
        end
        ST_OUT0: if (out_ready) state <= ST_OUT1;
        ST_OUT1: if (out_ready) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    out_valid = (state == ST_OUT0) || (state == ST_OUT1);
    out_data  = '0;
    if (state == ST_OUT0) out_data = DATA_W'({best_func, best_thr});
    else if (state == ST_OUT1) out_data = DATA_W'(best_idx);
  end
  assign done = (state == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data)); // R8
  AST_BUSY_STAYS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COMP || state == ST_SCAN) |=> state != ST_IDLE); // R2
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (out_valid || done) |-> !in_ready); // R3
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    cand_valid |-> cand_idx <= count); // R5
endmodule

// File: tb/thresh_learn_seq_tb.sv
module thresh_learn_seq_tb;
  localparam int NV = 7;
  localparam int TB_DEPTH = 16;

  localparam int VN [NV] = '{4, 2, 2, 4, 4, 1, 1};
  localparam logic [31:0] VW [NV][4] = '{
    '{32'h0000000A, 32'h00000014, 32'h800000C8, 32'h800000FA},
    '{32'h00000305, 32'h80000705, 32'h0, 32'h0},
    '{32'h8000000A, 32'h000000C8, 32'h0, 32'h0},
    '{32'h8000C800, 32'h800000C8, 32'h00000000, 32'h80006464},
    '{32'h0000FFFF, 32'h00000000, 32'h800000FF, 32'h8000FF00},
    '{32'h80000032, 32'h0, 32'h0, 32'h0},
    '{32'h00000032, 32'h0, 32'h0, 32'h0}
  };
  localparam int EF [NV] = '{0, 1, 0, 2, 3, 0, 0};
  localparam int ET [NV] = '{21, 4, 0, 1, 1, 0, 51};
  localparam int EI [NV] = '{0, 0, 1, 0, 0, 0, 0};
  localparam string VR [NV] = '{"R4 funcA", "R4 funcB", "R6 tie", "R4 avg",
                                "R4 xor", "R5 ge-boundary", "R5 above"};

  logic clk = 0, rst = 1;
  logic in_valid = 0, start = 0, out_ready = 0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, done;
  logic [31:0] out_data;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  thresh_learn_seq #(.DEPTH(TB_DEPTH)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .start(start), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d cycles exp=<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic collect(input string req, input int ef, input int et, input int ei, input int stall);
    logic [31:0] w0;
    out_ready = 0;
    while (!out_valid) @(negedge clk);
    w0 = out_data;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check(out_valid && out_data == w0, "R8 hold", longint'(out_data), longint'(w0));
    end
    out_ready = 1;
    check(out_data == {22'b0, 2'(ef), 8'(et)}, {req, " R7 word0"},
          longint'(out_data), longint'({22'b0, 2'(ef), 8'(et)}));
    @(negedge clk);
    check(out_valid && out_data == 32'(ei), {req, " R7 index"}, longint'(out_data), longint'(ei));
    check(!done, "R9 early", longint'(done), 0);
    @(negedge clk);
    out_ready = 0;
    check(done && !out_valid, "R9 done", longint'(done), 1);
    @(negedge clk);
    check(!done, "R9 single", longint'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready && !out_valid && !done, "R10 reset", longint'({in_ready, out_valid, done}), 3'b100);
    rst = 0;
    @(negedge clk);
    check(in_ready && !out_valid && !done, "R10 after reset", longint'({in_ready, out_valid, done}), 3'b100);

    pulse_start();
    repeat (10) @(negedge clk);
    check(!out_valid && in_ready, "R2 empty start", longint'({out_valid, in_ready}), 2'b01);

    for (int v = 0; v < NV; v++) begin
      for (int j = 0; j < VN[v]; j++) push(VW[v][j]);
      pulse_start();
      @(negedge clk);
      check(!in_ready, "R3 busy", longint'(in_ready), 0);
      collect(VR[v], EF[v], ET[v], EI[v], 0);
    end

    for (int i = 0; i < TB_DEPTH; i++) push({(i >= 8), 23'b0, 8'(i * 10)});
    check(!in_ready, "R1 full", longint'(in_ready), 0);
    @(negedge clk);
    in_valid = 1; in_data = 32'h800000FF;
    repeat (3) @(negedge clk);
    check(!in_ready, "R1 full hold", longint'(in_ready), 0);
    in_valid = 0;
    pulse_start();
    repeat (20) @(negedge clk);
    in_valid = 1; in_data = 32'h80000000; start = 1;
    @(negedge clk);
    check(!in_ready, "R3 load while busy", longint'(in_ready), 0);
    in_valid = 0; start = 0;
    pulse_start();
    collect("R1 full set", 0, 71, 0, 5);

    push(32'h00000032);
    pulse_start();
    collect("R9 store cleared", 0, 51, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule